// File: doc/BRIEF.md
# Multi-Mode Compare Counter/Timer

This block is a timer made of two 16-bit halves, A and B. Each half counts qualified ticks and produces a waveform on its own output pin. The waveform depends on a 3-bit function code and on four compare registers. The available shapes are:

- a single terminal event and a periodic terminal pulse;
- a one-time pulse and a repeating rectangular wave;
- a two-setting alternating wave;
- a free-running count with one level change;
- a serial bit burst taken from the compare registers, emitted either once or repeatedly.

Setting a join bit chains the halves into one 32-bit counter, and that counter is controlled by half A's settings. Each half also has an interrupt pulse and a sticky status bit. Software configures the block through a small synchronous write port and a combinational read port.

The tick input stands in for the selected clock source. A counter advances only on clock edges where tick, the global run input and the half's own enable are all high.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every configuration, compare, join and status register reads 0, the count reads 0, and out_a, out_b, irq_a and irq_b are 0.
- R2: Function code 0 (single count). Each step adds one to the count. On the step where the count equals compare 0, the raw output goes to 1 and holds there, and exactly one event fires. The function codes are 0 single count, 1 repeated count, 2 one-time pulse, 3 repeated pulse, 4 single pattern, 5 repeated pattern, 6 free-running, 7 alternating pulse.
- R3: Function code 1 (repeated count). On the step where the count equals compare 0, the count restarts at 0, the output is 1 for exactly one clock, and an event fires. This repeats every compare 0 + 1 steps.
- R4: Function code 2 (one-time pulse). The output rises after the step at count = compare 0 and falls after the step at count = compare 1. At the fall one event fires, and after that the output stays low.
- R5: Function code 3 (repeated pulse) behaves like code 2 but restarts from 0 after the falling step. The period is compare 1 + 1 steps, the high time is compare 1 − compare 0 steps, and one event fires per period.
- R6: Function code 7 (alternating pulse) behaves like code 3, but the settings change on every restart. The first period uses compare 0 and compare 1 as the rise and end points; the next uses compare 2 and compare 3; then the two pairs keep taking turns.
- R7: Function code 4 (single pattern). Each step drives the pattern bit indexed by the count. The pattern is the 64-bit word made of the compare registers, with compare 0 in bits 15:0 up to compare 3 in bits 63:48, so bits go out least-significant first. The step whose count equals the 6-bit limit field emits the last bit and fires an event. Every later step drives 0.
- R8: Function code 5 (repeated pattern) behaves like code 4, but after the limit bit it restarts at bit 0.
- R9: Function code 6 (free-running). The count advances on every step and never stops at a compare value. The output rises, and a single event fires, only the first time the count equals compare 0.
- R10: The count changes only when tick, glb_en and the half's enable bit are all 1. While the half's clear bit is 1, the count and the waveform state are held at 0 even when the half is enabled.
- R11: When the join bit is 1, half A counts as a 32-bit counter. Its compare value n is {B compare n, A compare n}, and it runs on A's configuration. Half B is held cleared, and the count register reads the full 32-bit value. When the join bit is 0, the count register reads {B count, A count}.
- R12: Output select values:
  - 0: the pin shows the raw output XOR the polarity bit.
  - 1: the pin shows the secondary output, which toggles on every event of that half and starts at 0.
  - 2: the pin is 0.
  - 3: the pin is 1.
- R13: An event with the interrupt-enable bit set gives a one-clock irq pulse in the clock after the event's step. Each irq pulse sets that half's status bit, which stays set until software writes a 1 to it; a set and a clear in the same clock leave the bit set. With the enable bit clear, the half gives no irq pulse and leaves its status bit at 0.
- R14: Register map, by word address:
  - 0: half A configuration.
  - 1: half B configuration.
  - 2: join bit, in bit 0.
  - 3: status, with A in bit 0 and B in bit 1, write 1 to clear.
  - 4–7: A compares 0–3.
  - 8–11: B compares 0–3.
  - 12: count, read only.

  A configuration word holds: enable in bit 0, clear in bit 1, function code in bits 4:2, polarity in bit 5, interrupt enable in bit 6, output select in bits 8:7, and limit in bits 14:9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global run gate shared by both halves |
| tick | input | 1 | Count qualifier standing in for the clock source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| out_a | output | 1 | Half A output pin |
| out_b | output | 1 | Half B output pin |
| irq_a | output | 1 | Half A interrupt pulse |
| irq_b | output | 1 | Half B interrupt pulse |

## Verification
The assertions check the following properties on every cycle:
- with the global gate low, the count holds;
- a set clear bit forces the count to zero;
- half B stays idle while the halves are joined;
- the forced output-select values pin the output;
- every irq pulse comes from an enabled half and leaves its status bit set.

Waveform shapes can only be shown by the bench's scenarios: rise and fall times, periods, the turn-taking between settings, the pattern bit order with its idle tail, the single event of the free-running mode, and the carry into the upper half when the halves are joined. For each of these, the bench computes the expected clock of the change from the requirements.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
    localparam int NCMP   = 4;
    localparam int LMT_W  = 6;
    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        FN_CNT_ONCE = 3'd0,
        FN_CNT_RPT  = 3'd1,
        FN_PWM_ONCE = 3'd2,
        FN_PWM_RPT  = 3'd3,
        FN_PAT_ONCE = 3'd4,
        FN_PAT_RPT  = 3'd5,
        FN_FREE     = 3'd6,
        FN_PWM_ALT  = 3'd7
    } tfn_e;

    typedef enum logic [1:0] {
        OS_NORM = 2'd0,
        OS_SEC  = 2'd1,
        OS_LOW  = 2'd2,
        OS_HIGH = 2'd3
    } osel_e;

    typedef struct packed {
        logic [LMT_W-1:0] lmt;
        osel_e            osel;
        logic             ie;
        logic             pol;
        tfn_e             fn;
        logic             clr;
        logic             en;
    } half_cfg_t;

    localparam int CFG_W = $bits(half_cfg_t);

    localparam logic [ADDR_W-1:0] AD_CFG_A = 4'd0;
    localparam logic [ADDR_W-1:0] AD_CFG_B = 4'd1;
    localparam logic [ADDR_W-1:0] AD_JOIN  = 4'd2;
    localparam logic [ADDR_W-1:0] AD_STS   = 4'd3;
    localparam logic [ADDR_W-1:0] AD_CNT   = 4'd12;

    function automatic logic pin_drive(osel_e s, logic pol, logic raw, logic sec);
        unique case (s)
            OS_NORM: return raw ^ pol;
            OS_SEC:  return sec;
            OS_LOW:  return 1'b0;
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/ctm_regs.sv
module ctm_regs
    import ctm_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [HW-1:0]               wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [2*HW-1:0]             rd_data,
    input  logic [2*HW-1:0]             cnt_word,
    input  logic [1:0]                  irq_set,
    output half_cfg_t                   cfg_a,
    output half_cfg_t                   cfg_b,
    output logic                        join_q,
    output logic [NCMP-1:0][HW-1:0]     cmp_a,
    output logic [NCMP-1:0][HW-1:0]     cmp_b,
    output logic [1:0]                  sts
);
    logic [1:0] sts_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a  <= '0;
            cfg_b  <= '0;
            join_q <= 1'b0;
            cmp_a  <= '0;
            cmp_b  <= '0;
        end else if (wr_en) begin
            if (wr_addr == AD_CFG_A) cfg_a  <= half_cfg_t'(wr_data[CFG_W-1:0]);
            if (wr_addr == AD_CFG_B) cfg_b  <= half_cfg_t'(wr_data[CFG_W-1:0]);
            if (wr_addr == AD_JOIN)  join_q <= wr_data[0];
            if (wr_addr[3:2] == 2'b01) cmp_a[wr_addr[1:0]] <= wr_data;
            if (wr_addr[3:2] == 2'b10) cmp_b[wr_addr[1:0]] <= wr_data;
        end
    end

    assign sts_clr = (wr_en && wr_addr == AD_STS) ? wr_data[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) sts <= 2'b00;
        else     sts <= (sts & ~sts_clr) | irq_set;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr[3:2])
            2'b01:   rd_data[HW-1:0] = cmp_a[rd_addr[1:0]];
            2'b10:   rd_data[HW-1:0] = cmp_b[rd_addr[1:0]];
            default: begin
                if (rd_addr == AD_CFG_A) rd_data[CFG_W-1:0] = cfg_a;
                if (rd_addr == AD_CFG_B) rd_data[CFG_W-1:0] = cfg_b;
                if (rd_addr == AD_JOIN)  rd_data[0]         = join_q;
                if (rd_addr == AD_STS)   rd_data[1:0]       = sts;
                if (rd_addr == AD_CNT)   rd_data            = cnt_word;
            end
        endcase
    end
endmodule

// File: rtl/ctm_core.sv
module ctm_core
    import ctm_pkg::*;
#(
    parameter int W  = 16,
    parameter int HW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step,
    input  logic                   clr,
    input  tfn_e                   fn,
    input  logic [NCMP-1:0][W-1:0] cmp,
    input  logic [LMT_W-1:0]       lmt,
    input  logic                   ie,
    input  logic [W-1:0]           mask,
    output logic [W-1:0]           cnt,
    output logic                   out_raw,
    output logic                   out_sec,
    output logic                   irq
);
    localparam int PAT_W = NCMP * HW;
    localparam int PW    = $clog2(PAT_W);

    logic [PAT_W-1:0] pat;
    logic             done, phase;
    logic [W-1:0]     n_cnt, inc, lo, hi;
    logic             n_out, n_done, n_phase, evt;

    always_comb begin
        for (int i = 0; i < NCMP; i++) pat[i*HW +: HW] = cmp[i][HW-1:0];
    end

    assign inc = (cnt + W'(1)) & mask;
    assign lo  = phase ? cmp[2] : cmp[0];
    assign hi  = phase ? cmp[3] : cmp[1];

    always_comb begin
        n_cnt   = cnt;
        n_out   = out_raw;
        n_done  = done;
        n_phase = phase;
        evt     = 1'b0;
        if (fn == FN_CNT_RPT) n_out = 1'b0;
        if (step && done && fn == FN_PAT_ONCE) n_out = 1'b0;
        if (step && !done) begin
            unique case (fn)
                FN_CNT_ONCE, FN_CNT_RPT: begin
                    if (cnt == cmp[0]) begin
                        n_out = 1'b1;
                        evt   = 1'b1;
                        if (fn == FN_CNT_ONCE) n_done = 1'b1;
                        else                   n_cnt  = '0;
                    end else begin
                        n_cnt = inc;
                    end
                end
                FN_PWM_ONCE, FN_PWM_RPT, FN_PWM_ALT: begin
                    if (cnt == hi) begin
                        n_cnt = '0;
                        n_out = 1'b0;
                        evt   = 1'b1;
                        if (fn == FN_PWM_ONCE) n_done  = 1'b1;
                        if (fn == FN_PWM_ALT)  n_phase = ~phase;
                    end else begin
                        n_cnt = inc;
                        if (cnt == lo) n_out = 1'b1;
                    end
                end
                FN_PAT_ONCE, FN_PAT_RPT: begin
                    n_out = pat[cnt[PW-1:0]];
                    if (cnt == W'(lmt)) begin
                        evt   = 1'b1;
                        n_cnt = '0;
                        if (fn == FN_PAT_ONCE) n_done = 1'b1;
                    end else begin
                        n_cnt = inc;
                    end
                end
                default: begin
                    n_cnt = inc;
                    if (!phase && cnt == cmp[0]) begin
                        n_out   = 1'b1;
                        n_phase = 1'b1;
                        evt     = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt     <= '0;
            out_raw <= 1'b0;
            done    <= 1'b0;
            phase   <= 1'b0;
            out_sec <= 1'b0;
            irq     <= 1'b0;
        end else begin
            cnt     <= n_cnt;
            out_raw <= n_out;
            done    <= n_done;
            phase   <= n_phase;
            out_sec <= out_sec ^ evt;
            irq     <= evt & ie;
        end
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import ctm_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              glb_en,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [HW-1:0]     wr_data,
    input  logic [3:0]        rd_addr,
    output logic [2*HW-1:0]   rd_data,
    output logic              out_a,
    output logic              out_b,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int WW = 2 * HW;

    half_cfg_t                  cfg_a, cfg_b;
    logic                       join_q;
    logic [NCMP-1:0][HW-1:0]    cmp_a, cmp_b;
    logic [NCMP-1:0][WW-1:0]    cmp_wide;
    logic [1:0]                 sts;
    logic [WW-1:0]              cnt_a, mask_a, cnt_word;
    logic [HW-1:0]              cnt_b;
    logic                       raw_a, sec_a, raw_b, sec_b;

    ctm_regs #(.HW(HW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_word(cnt_word),
        .irq_set({irq_b, irq_a}), .cfg_a(cfg_a), .cfg_b(cfg_b), .join_q(join_q),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .sts(sts)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign cmp_wide[g] = join_q ? {cmp_b[g], cmp_a[g]} : {{HW{1'b0}}, cmp_a[g]};
    end

    assign mask_a   = join_q ? {WW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};
    assign cnt_word = join_q ? cnt_a : {cnt_b, cnt_a[HW-1:0]};

    ctm_core #(.W(WW), .HW(HW)) u_core_a (
        .clk(clk), .rst(rst), .step(tick & glb_en & cfg_a.en), .clr(cfg_a.clr),
        .fn(cfg_a.fn), .cmp(cmp_wide), .lmt(cfg_a.lmt), .ie(cfg_a.ie), .mask(mask_a),
        .cnt(cnt_a), .out_raw(raw_a), .out_sec(sec_a), .irq(irq_a)
    );

    ctm_core #(.W(HW), .HW(HW)) u_core_b (
        .clk(clk), .rst(rst), .step(tick & glb_en & cfg_b.en), .clr(cfg_b.clr | join_q),
        .fn(cfg_b.fn), .cmp(cmp_b), .lmt(cfg_b.lmt), .ie(cfg_b.ie), .mask({HW{1'b1}}),
        .cnt(cnt_b), .out_raw(raw_b), .out_sec(sec_b), .irq(irq_b)
    );

    assign out_a = pin_drive(cfg_a.osel, cfg_a.pol, raw_a, sec_a);
    assign out_b = pin_drive(cfg_b.osel, cfg_b.pol, raw_b, sec_b);
endmodule

// File: rtl/ctm_chk.sv
module ctm_chk
    import ctm_pkg::*;
#(
    parameter int HW = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            glb_en,
    input logic            clr_a,
    input logic            ie_a,
    input osel_e           osel_a,
    input logic            join_q,
    input logic [2*HW-1:0] cnt_a,
    input logic [HW-1:0]   cnt_b,
    input logic            out_a,
    input logic            irq_a,
    input logic            sts_a
);
    a_r10_glb_hold: assert property (@(posedge clk) disable iff (rst)
        (!glb_en && !clr_a) |=> $stable(cnt_a));

    a_r10_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr_a |=> (cnt_a == '0));

    a_r11_b_idle: assert property (@(posedge clk) disable iff (rst)
        join_q |=> (cnt_b == '0));

    a_r12_force_low: assert property (@(posedge clk) disable iff (rst)
        (osel_a == OS_LOW) |-> !out_a);

    a_r12_force_high: assert property (@(posedge clk) disable iff (rst)
        (osel_a == OS_HIGH) |-> out_a);

    a_r13_sticky: assert property (@(posedge clk) disable iff (rst)
        irq_a |=> sts_a);

    a_r13_enabled: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> $past(ie_a));
endmodule

bind cmp_timer ctm_chk #(.HW(HW)) u_chk (
    .clk(clk), .rst(rst), .glb_en(glb_en), .clr_a(cfg_a.clr), .ie_a(cfg_a.ie),
    .osel_a(cfg_a.osel), .join_q(join_q), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .out_a(out_a), .irq_a(irq_a), .sts_a(sts[0])
);

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        glb_en = 1'b1;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        out_a, out_b, irq_a, irq_b;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cmp_timer u_cmp_timer (
        .clk(clk), .rst(rst), .glb_en(glb_en), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_a(out_a), .out_b(out_b), .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic [15:0] ctl(logic en, logic clr, logic [2:0] fn, logic pol,
                                        logic ie, logic [1:0] os, logic [5:0] lmt);
        return {1'b0, lmt, os, ie, pol, fn, clr, en};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // clear A, load its compares, clear status, leave at the start write
    task automatic setup_a(logic [15:0] c0, logic [15:0] c1, logic [15:0] c2, logic [15:0] c3);
        wr(4'd0, ctl(1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0, 6'd0));
        wr(4'd4, c0); wr(4'd5, c1); wr(4'd6, c2); wr(4'd7, c3);
        wr(4'd3, 16'h0003);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd12, d); check("R1 count", d, 0);
        rd(4'd0, d);  check("R1 cfg A", d, 0);
        rd(4'd3, d);  check("R1 status", d, 0);
        rd(4'd4, d);  check("R14 cmp A0", d, 0);
        check("R1 pins", {out_a, out_b, irq_a, irq_b}, 0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        setup_a(16'd3, 0, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd0, 6'd0));
        wait_n(3); check("R2 before hit", out_a, 0);
        wait_n(1); check("R2 at hit", {out_a, irq_a}, 2'b11);
        wait_n(1); check("R13 irq one clock", irq_a, 0);
        wait_n(5); check("R2 holds", out_a, 1);
        rd(4'd3, d); check("R13 sticky", d, 1);
        wr(4'd3, 16'h0001);
        rd(4'd3, d); check("R13 write one clears", d, 0);
    endtask

    task automatic t_repeat();
        int hi = 0;
        setup_a(16'd2, 0, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 2'd0, 6'd0));
        for (int i = 1; i <= 9; i++) begin
            wait_n(1);
            if (out_a) hi++;
            if (i == 3) check("R3 pulse", out_a, 1);
            if (i == 4) check("R3 one clock wide", out_a, 0);
        end
        check("R3 pulse count", hi, 3);
    endtask

    task automatic t_pwm();
        int hi = 0;
        setup_a(16'd1, 16'd4, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 2'd0, 6'd0));
        for (int i = 1; i <= 10; i++) begin
            wait_n(1);
            if (out_a) hi++;
            if (i == 2) check("R5 rise", out_a, 1);
            if (i == 5) check("R5 fall", out_a, 0);
        end
        check("R5 high steps", hi, 6);
    endtask

    task automatic t_oneshot();
        setup_a(16'd1, 16'd3, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd2, 1'b0, 1'b1, 2'd0, 6'd0));
        wait_n(2); check("R4 rise", out_a, 1);
        wait_n(2); check("R4 fall and event", {out_a, irq_a}, 2'b01);
        wait_n(6); check("R4 stays low", out_a, 0);
    endtask

    task automatic t_alt();
        logic [7:0] got = '0;
        setup_a(16'd0, 16'd1, 16'd1, 16'd4);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd7, 1'b0, 1'b0, 2'd0, 6'd0));
        for (int i = 1; i <= 8; i++) begin
            wait_n(1);
            got[i-1] = out_a;
        end
        // N1..N8 expected 1,0,0,1,1,1,0,1 (bit0 = N1)
        check("R6 alternating shape", got, 8'b1011_1001);
    endtask

    task automatic t_pattern();
        logic [8:0] got = '0;
        setup_a(16'h00B5, 0, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 2'd0, 6'd5));
        for (int i = 1; i <= 9; i++) begin
            wait_n(1);
            got[i-1] = out_a;
            if (i == 6) check("R7 event on limit bit", irq_a, 1);
        end
        check("R7 burst then idle low", got, 9'b0_0011_0101);
        setup_a(16'h0003, 0, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd5, 1'b0, 1'b0, 2'd0, 6'd2));
        got = '0;
        for (int i = 1; i <= 7; i++) begin
            wait_n(1);
            got[i-1] = out_a;
        end
        check("R8 repeated burst", got[6:0], 7'b101_1011);
    endtask

    task automatic t_free();
        logic [31:0] d;
        int nirq = 0;
        setup_a(16'd2, 0, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd6, 1'b0, 1'b1, 2'd0, 6'd0));
        for (int i = 1; i <= 10; i++) begin
            wait_n(1);
            if (irq_a) nirq++;
            if (i == 3) check("R9 level change", out_a, 1);
        end
        check("R9 single event", nirq, 1);
        rd(4'd12, d); check("R9 keeps counting", d, 10);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        setup_a(16'd100, 0, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd6, 1'b0, 1'b0, 2'd0, 6'd0));
        wait_n(5); rd(4'd12, d); check("R10 counting", d, 5);
        glb_en = 1'b0;
        wait_n(4); rd(4'd12, d); check("R10 global gate", d, 5);
        glb_en = 1'b1; tick = 1'b0;
        wait_n(3); rd(4'd12, d); check("R10 tick gate", d, 5);
        tick = 1'b1;
        wait_n(2); rd(4'd12, d); check("R10 resumes", d, 7);
        wr(4'd0, ctl(1'b1, 1'b1, 3'd6, 1'b0, 1'b0, 2'd0, 6'd0));
        wait_n(3); rd(4'd12, d); check("R10 clear holds zero", d, 0);
    endtask

    task automatic t_pins();
        setup_a(16'd3, 0, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 2'd0, 6'd0));
        wait_n(1); check("R12 inverted idle", out_a, 1);
        wait_n(3); check("R12 inverted hit", out_a, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 2'd2, 6'd0));
        check("R12 forced 0", out_a, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 2'd3, 6'd0));
        check("R12 forced 1", out_a, 1);
        setup_a(16'd2, 0, 0, 0);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 2'd1, 6'd0));
        wait_n(2); check("R12 secondary start", out_a, 0);
        wait_n(1); check("R12 secondary toggles", out_a, 1);
        wait_n(3); check("R12 secondary toggles back", out_a, 0);
    endtask

    task automatic t_irq_enable();
        logic [31:0] d;
        int nirq = 0;
        setup_a(16'd1, 0, 0, 0);
        wr(4'd1, ctl(1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0, 6'd0));
        wr(4'd8, 16'd1);
        wr(4'd1, ctl(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd0, 6'd0));
        wr(4'd0, ctl(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 2'd0, 6'd0));
        for (int i = 1; i <= 6; i++) begin
            wait_n(1);
            if (irq_a) nirq++;
        end
        check("R13 disabled half silent", nirq, 0);
        check("R2 half B reached compare", out_b, 1);
        rd(4'd3, d); check("R13 only B status", d, 2);
        wr(4'd3, 16'h0002);
        rd(4'd3, d); check("R13 B cleared", d, 0);
    endtask

    task automatic t_join();
        logic [31:0] d;
        wr(4'd1, ctl(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 2'd0, 6'd0));
        setup_a(16'd5, 0, 0, 0);
        wr(4'd8, 16'd1);
        wr(4'd2, 16'd1);
        wr(4'd0, ctl(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 2'd0, 6'd0));
        wait_n(65541);
        check("R11 no hit on low half", out_a, 0);
        rd(4'd12, d); check("R11 32-bit count", d, 32'h0001_0005);
        wait_n(1); check("R11 hit on joined compare", out_a, 1);
        wr(4'd2, 16'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_single();
        t_repeat();
        t_pwm();
        t_oneshot();
        t_alt();
        t_pattern();
        t_free();
        t_gate();
        t_pins();
        t_irq_enable();
        t_join();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule